// File: doc/BRIEF.md
# Fetch Redirect and Instruction Kill Control

This block owns the program counter of a five-stage in-order pipeline and chooses where the next fetch comes from. Fetch always guesses the sequential address (current PC plus 4). Unconditional jumps are recognised in decode and conditional branches are resolved in execute. When a guess turns out wrong, the block steers the PC to the correct target and tells the pipeline which instruction registers must be loaded with a no-op so that the wrongly fetched instructions never complete.

The surrounding datapath gives the block the opcode class of the decode-stage and execute-stage instructions, the execute-stage zero flag, the decode-stage jump immediate and register value, the execute-stage branch offset, and the interlock stall. The block returns the fetch address, the PC source select, the two no-op selects and a decode hold enable. It keeps its own copies of the decode and execute instruction addresses, so it can form both targets with its own adders.

Top module: `fr_redirect_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it is released, the fetch address is 0 and the decode and execute copies of the PC are 0.
- R2: Opcode class codes on both opcode inputs are 3 bits: 0 other, 1 J, 2 JAL, 3 JR, 4 JALR, 5 BEQZ, 6 BNEZ, 7 other. The PC source select is 2 bits: 0 sequential, 1 absolute jump, 2 register indirect, 3 branch target. A taken branch in execute selects 3 whatever decode holds and whatever the stall input is.
- R3: A BEQZ in execute is taken when the zero flag is 1. A BNEZ in execute is taken when the zero flag is 0. Otherwise it is not taken and causes no redirect.
- R4: When no branch is taken, J or JAL in decode selects 1, and the next fetch address is the decode PC plus the sign-extended 26-bit immediate shifted left by 2.
- R5: When no branch is taken and decode holds no J or JAL, JR or JALR in decode selects 2, and the next fetch address is the register value input.
- R6: With no redirect and no stall, the select is 0 and the fetch address advances by 4 each cycle.
- R7: The decode no-op select is 1 exactly when execute holds a taken branch or decode holds J, JAL, JR or JALR. This kills one instruction after a jump and, together with R8, two after a taken branch.
- R8: The execute no-op select is 1 when execute holds a taken branch or when stall is 1. Otherwise it is 0.
- R9: A kill takes precedence over a stall. The decode hold output is 1 only when stall is 1 and no redirect is active. While it is 1, the fetch address and the decode PC keep their values.
- R10: The branch target is the execute-stage PC plus the sign-extended 16-bit byte offset.
- R11: Branch classes in decode and jump classes in execute do not redirect the PC and kill nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Interlock stall from hazard logic |
| dec_op_i | input | 3 | Opcode class of the decode-stage instruction |
| dec_jimm_i | input | 26 | Jump immediate (word offset) of the decode-stage instruction |
| dec_rs_val_i | input | 32 | Register value used by JR and JALR in decode |
| exe_op_i | input | 3 | Opcode class of the execute-stage instruction |
| exe_zero_i | input | 1 | Execute-stage flag: tested register equals zero |
| exe_boff_i | input | 16 | Branch byte offset of the execute-stage instruction |
| fetch_pc_o | output | 32 | Address sent to instruction memory this cycle |
| pc_sel_o | output | 2 | PC source select (code values in R2) |
| dec_ir_nop_o | output | 1 | Load a no-op into the decode instruction register |
| exe_ir_nop_o | output | 1 | Load a no-op into the execute instruction register |
| dec_ir_hold_o | output | 1 | Decode instruction register keeps its value |

## Verification
A wrong internal PC copy stays hidden until a jump or branch uses it. The error then shows up one cycle later as a wrong fetch address. For this reason the sequences place jumps and branches after several plain cycles and after a stall, so that a copy that failed to hold or to advance lands on a wrong address. A priority or kill error shows up in the same cycle on the select outputs. The cases that would expose it are a branch, a jump and a stall arriving together, and branch or jump classes in the stage where they must be ignored.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int unsigned XLEN = 32;

    typedef logic [XLEN-1:0] addr_t;

    typedef enum logic [2:0] {
        OP_OTHER = 3'd0,
        OP_J     = 3'd1,
        OP_JAL   = 3'd2,
        OP_JR    = 3'd3,
        OP_JALR  = 3'd4,
        OP_BEQZ  = 3'd5,
        OP_BNEZ  = 3'd6,
        OP_RSVD  = 3'd7
    } op_cls_e;

    typedef enum logic [1:0] {
        SRC_SEQ  = 2'd0,
        SRC_JABS = 2'd1,
        SRC_RIND = 2'd2,
        SRC_BR   = 2'd3
    } pc_src_e;

    typedef struct packed {
        addr_t fetch_pc;
        addr_t dec_pc;
        addr_t exe_pc;
    } pc_pipe_t;

endpackage

// File: rtl/fr_branch_eval.sv
module fr_branch_eval
    import fr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  op_cls_e exe_op,
    input  logic    exe_zero,
    output logic    taken
);

    logic is_eqz_d;
    logic is_nez_d;

    always_comb begin
        is_eqz_d = (exe_op == OP_BEQZ);
        is_nez_d = (exe_op == OP_BNEZ);
        taken    = (is_eqz_d && exe_zero) || (is_nez_d && !exe_zero);
    end

    p_beqz_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_op == OP_BEQZ && exe_zero) |-> taken);

    p_bnez_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_op == OP_BNEZ && !exe_zero) |-> taken);

    p_nonbranch_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_op != OP_BEQZ && exe_op != OP_BNEZ) |-> !taken);

endmodule

// File: rtl/fr_redirect_sel.sv
module fr_redirect_sel
    import fr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    br_taken,
    input  op_cls_e dec_op,
    input  logic    stall,
    output pc_src_e pc_src,
    output logic    dec_kill,
    output logic    exe_kill,
    output logic    dec_hold
);

    logic jabs_d;
    logic jind_d;
    logic redirect_d;

    always_comb begin
        jabs_d = (dec_op == OP_J)  || (dec_op == OP_JAL);
        jind_d = (dec_op == OP_JR) || (dec_op == OP_JALR);

        // older instruction (execute) wins over younger (decode)
        if (br_taken)    pc_src = SRC_BR;
        else if (jabs_d) pc_src = SRC_JABS;
        else if (jind_d) pc_src = SRC_RIND;
        else             pc_src = SRC_SEQ;

        redirect_d = br_taken || jabs_d || jind_d;
        dec_kill   = redirect_d;
        exe_kill   = br_taken || stall;
        // kill overrides stall: hold only when nothing redirects
        dec_hold   = stall && !redirect_d;
    end

    p_branch_kills_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (dec_kill && exe_kill && pc_src == SRC_BR));

    p_stall_bubbles_exe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> exe_kill);

    p_hold_or_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_hold, dec_kill}));

    p_jump_kills_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_taken && (pc_src == SRC_JABS || pc_src == SRC_RIND)) |-> (dec_kill && (exe_kill == stall)));

endmodule

// File: rtl/fr_target_gen.sv
module fr_target_gen
    import fr_pkg::*;
#(
    parameter int unsigned JIMM_W = 26,
    parameter int unsigned BOFF_W = 16,
    parameter int unsigned JSHIFT = 2,
    parameter int unsigned STEP   = 4
) (
    input  addr_t             fetch_pc,
    input  addr_t             dec_pc,
    input  addr_t             exe_pc,
    input  logic [JIMM_W-1:0] jimm,
    input  logic [BOFF_W-1:0] boff,
    output addr_t             seq_tgt,
    output addr_t             jabs_tgt,
    output addr_t             br_tgt
);

    localparam int unsigned JW = JIMM_W + JSHIFT;

    addr_t jofs_d;
    addr_t bofs_d;

    generate
        if (JW >= XLEN) begin : g_jofs_trunc
            logic [JW-1:0] jwide_d;
            always_comb begin
                jwide_d = {jimm, {JSHIFT{1'b0}}};
                jofs_d  = jwide_d[XLEN-1:0];
            end
        end else begin : g_jofs_sext
            always_comb jofs_d = {{(XLEN-JW){jimm[JIMM_W-1]}}, jimm, {JSHIFT{1'b0}}};
        end

        if (BOFF_W >= XLEN) begin : g_bofs_trunc
            always_comb bofs_d = boff[XLEN-1:0];
        end else begin : g_bofs_sext
            always_comb bofs_d = {{(XLEN-BOFF_W){boff[BOFF_W-1]}}, boff};
        end
    endgenerate

    always_comb begin
        seq_tgt  = fetch_pc + addr_t'(STEP);
        jabs_tgt = dec_pc + jofs_d;
        br_tgt   = exe_pc + bofs_d;
    end

endmodule

// File: rtl/fr_redirect_ctrl.sv
module fr_redirect_ctrl
    import fr_pkg::*;
#(
    parameter int unsigned JIMM_W   = 26,
    parameter int unsigned BOFF_W   = 16,
    parameter int unsigned OP_W     = 3,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic [OP_W-1:0]   dec_op_i,
    input  logic [JIMM_W-1:0] dec_jimm_i,
    input  logic [31:0]       dec_rs_val_i,
    input  logic [OP_W-1:0]   exe_op_i,
    input  logic              exe_zero_i,
    input  logic [BOFF_W-1:0] exe_boff_i,
    output logic [31:0]       fetch_pc_o,
    output logic [1:0]        pc_sel_o,
    output logic              dec_ir_nop_o,
    output logic              exe_ir_nop_o,
    output logic              dec_ir_hold_o
);

    pc_pipe_t st_d, st_q;
    op_cls_e  dec_op_w, exe_op_w;
    pc_src_e  pc_src_w;
    logic     br_taken_w, dec_kill_w, exe_kill_w, dec_hold_w;
    addr_t    seq_tgt_w, jabs_tgt_w, br_tgt_w, next_pc_w;

    always_comb begin
        dec_op_w = op_cls_e'(dec_op_i);
        exe_op_w = op_cls_e'(exe_op_i);
    end

    fr_branch_eval u_beval (
        .clk      (clk),
        .rst_n    (rst_n),
        .exe_op   (exe_op_w),
        .exe_zero (exe_zero_i),
        .taken    (br_taken_w)
    );

    fr_redirect_sel u_rsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_taken (br_taken_w),
        .dec_op   (dec_op_w),
        .stall    (stall_i),
        .pc_src   (pc_src_w),
        .dec_kill (dec_kill_w),
        .exe_kill (exe_kill_w),
        .dec_hold (dec_hold_w)
    );

    fr_target_gen #(
        .JIMM_W (JIMM_W),
        .BOFF_W (BOFF_W)
    ) u_tgen (
        .fetch_pc (st_q.fetch_pc),
        .dec_pc   (st_q.dec_pc),
        .exe_pc   (st_q.exe_pc),
        .jimm     (dec_jimm_i),
        .boff     (exe_boff_i),
        .seq_tgt  (seq_tgt_w),
        .jabs_tgt (jabs_tgt_w),
        .br_tgt   (br_tgt_w)
    );

    always_comb begin
        unique case (pc_src_w)
            SRC_BR:   next_pc_w = br_tgt_w;
            SRC_JABS: next_pc_w = jabs_tgt_w;
            SRC_RIND: next_pc_w = dec_rs_val_i;
            default:  next_pc_w = seq_tgt_w;
        endcase

        st_d = st_q;
        if (!dec_hold_w) begin
            st_d.fetch_pc = next_pc_w;
            st_d.dec_pc   = st_q.fetch_pc;
        end
        st_d.exe_pc = st_q.dec_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fetch_pc: RESET_PC, dec_pc: RESET_PC, exe_pc: RESET_PC};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        fetch_pc_o    = st_q.fetch_pc;
        pc_sel_o      = pc_src_w;
        dec_ir_nop_o  = dec_kill_w;
        exe_ir_nop_o  = exe_kill_w;
        dec_ir_hold_o = dec_hold_w;
    end

    p_seq_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel_o == 2'd0 && !dec_ir_hold_o) |=> (fetch_pc_o == $past(fetch_pc_o) + 32'd4));

    p_hold_keeps_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ir_hold_o |=> (fetch_pc_o == $past(fetch_pc_o)));

    p_rind_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel_o == 2'd2) |=> (fetch_pc_o == $past(dec_rs_val_i)));

    p_hold_freezes_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ir_hold_o |=> $stable(st_q.dec_pc));

endmodule

// File: tb/fr_redirect_ctrl_tb.sv
module fr_redirect_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic [2:0]  dec_op_i = 3'd0;
    logic [25:0] dec_jimm_i = '0;
    logic [31:0] dec_rs_val_i = '0;
    logic [2:0]  exe_op_i = 3'd0;
    logic        exe_zero_i = 1'b0;
    logic [15:0] exe_boff_i = '0;
    logic [31:0] fetch_pc_o;
    logic [1:0]  pc_sel_o;
    logic        dec_ir_nop_o, exe_ir_nop_o, dec_ir_hold_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fr_redirect_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .dec_op_i(dec_op_i), .dec_jimm_i(dec_jimm_i), .dec_rs_val_i(dec_rs_val_i),
        .exe_op_i(exe_op_i), .exe_zero_i(exe_zero_i), .exe_boff_i(exe_boff_i),
        .fetch_pc_o(fetch_pc_o), .pc_sel_o(pc_sel_o),
        .dec_ir_nop_o(dec_ir_nop_o), .exe_ir_nop_o(exe_ir_nop_o), .dec_ir_hold_o(dec_ir_hold_o)
    );

    typedef struct packed {
        logic        stall;
        logic [2:0]  dop;
        logic [25:0] jimm;
        logic [31:0] rs;
        logic [2:0]  eop;
        logic        zero;
        logic [15:0] boff;
        logic [31:0] pc;
        logic [1:0]  sel;
        logic        dn;
        logic        en;
        logic        hold;
    } vec_t;

    localparam int NVEC = 17;
    // codes: 0 other,1 J,2 JAL,3 JR,4 JALR,5 BEQZ,6 BNEZ; sel 0 seq,1 jabs,2 rind,3 br
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd0, 1'b0, 16'h0,    32'h000, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd0, 1'b0, 16'h0,    32'h004, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 3'd1, 26'h40,      32'h0,   3'd0, 1'b0, 16'h0,    32'h008, 2'd1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd1, 1'b0, 16'h0,    32'h104, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd0, 1'b0, 16'h0,    32'h108, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 3'd5, 26'h0,       32'h0,   3'd0, 1'b1, 16'h0,    32'h10C, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd5, 1'b1, 16'h40,   32'h110, 2'd3, 1'b1, 1'b1, 1'b0},
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd0, 1'b0, 16'h0,    32'h148, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 3'd6, 26'h0,       32'h0,   3'd0, 1'b0, 16'h0,    32'h14C, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd6, 1'b1, 16'h40,   32'h150, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 3'd0, 26'h0,       32'h0,   3'd0, 1'b0, 16'h0,    32'h154, 2'd0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 3'd3, 26'h0,       32'h200, 3'd0, 1'b0, 16'h0,    32'h154, 2'd2, 1'b1, 1'b1, 1'b0},
        '{1'b1, 3'd2, 26'h10,      32'h0,   3'd6, 1'b0, 16'hFFF8, 32'h200, 2'd3, 1'b1, 1'b1, 1'b0},
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd5, 1'b0, 16'h40,   32'h148, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 3'd4, 26'h0,       32'h3FC, 3'd0, 1'b0, 16'h0,    32'h14C, 2'd2, 1'b1, 1'b0, 1'b0},
        '{1'b0, 3'd2, 26'h3FFFFFF, 32'h0,   3'd0, 1'b0, 16'h0,    32'h3FC, 2'd1, 1'b1, 1'b0, 1'b0},
        '{1'b0, 3'd0, 26'h0,       32'h0,   3'd0, 1'b0, 16'h0,    32'h148, 2'd0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        stall_i = 1'b0; dec_op_i = 3'd0; dec_jimm_i = '0; dec_rs_val_i = '0;
        exe_op_i = 3'd0; exe_zero_i = 1'b0; exe_boff_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        drive_idle();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 fetch address in reset", fetch_pc_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // sequences: ADD, J, ADD and ADD, BEQZ taken, ADD, then stall/priority mixes
        for (int i = 0; i < NVEC; i++) begin
            stall_i      = VECS[i].stall;
            dec_op_i     = VECS[i].dop;
            dec_jimm_i   = VECS[i].jimm;
            dec_rs_val_i = VECS[i].rs;
            exe_op_i     = VECS[i].eop;
            exe_zero_i   = VECS[i].zero;
            exe_boff_i   = VECS[i].boff;
            #1;
            chk($sformatf("R4 R5 R6 R10 R1 fetch pc step %0d", i), fetch_pc_o, VECS[i].pc);
            chk($sformatf("R2 R3 R11 pc select step %0d", i), {30'h0, pc_sel_o}, {30'h0, VECS[i].sel});
            chk($sformatf("R7 decode nop step %0d", i), {31'h0, dec_ir_nop_o}, {31'h0, VECS[i].dn});
            chk($sformatf("R8 execute nop step %0d", i), {31'h0, exe_ir_nop_o}, {31'h0, VECS[i].en});
            chk($sformatf("R9 decode hold step %0d", i), {31'h0, dec_ir_hold_o}, {31'h0, VECS[i].hold});
            @(negedge clk);
        end

        // directed: reset in mid-run returns PC to zero
        drive_idle();
        rst_n = 1'b0;
        #1;
        chk("R1 fetch pc after mid-run reset", fetch_pc_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 fetch pc first cycle after reset", fetch_pc_o, 32'h0);
        // jump right after reset: decode PC copy must be 0 -> target 0 + 8*4
        dec_op_i = 3'd1; dec_jimm_i = 26'h8;
        @(negedge clk);
        drive_idle();
        #1;
        chk("R1 R4 jump uses reset decode pc", fetch_pc_o, 32'h20);
        // branch taken in execute beats stall and register-indirect jump
        stall_i = 1'b1; dec_op_i = 3'd4; dec_rs_val_i = 32'h800;
        exe_op_i = 3'd5; exe_zero_i = 1'b1; exe_boff_i = 16'h10;
        #1;
        chk("R2 R9 branch over jump and stall select", {30'h0, pc_sel_o}, 32'd3);
        chk("R9 no hold while killing", {31'h0, dec_ir_hold_o}, 32'd0);
        @(negedge clk);
        drive_idle();
        #1;
        // exe pc copy is decode pc of previous cycle = 0 (fetch pc was 0 two cycles back)
        chk("R10 branch target from reset exe pc", fetch_pc_o, 32'h10);
        // reserved class 7 in both stages is ignored
        dec_op_i = 3'd7; exe_op_i = 3'd7; exe_zero_i = 1'b1;
        #1;
        chk("R11 class 7 select", {30'h0, pc_sel_o}, 32'd0);
        chk("R11 class 7 no decode kill", {31'h0, dec_ir_nop_o}, 32'd0);
        @(negedge clk);
        drive_idle();
        #1;
        chk("R6 R11 sequential after class 7", fetch_pc_o, 32'h14);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule